// File: doc/BRIEF.md
# Double to Signed 64-bit Integer Converter

This block turns an IEEE-754 binary64 operand into a signed 64-bit two's-complement integer, in the same 64-bit register layout, together with three status flags: inexact, invalid and integer overflow. The operand, a two-bit rounding mode and a valid strobe enter on one clock edge. The result and flags leave registered on the next edge, with a matching output valid.

Overflow does not saturate. A finite value whose integer part does not fit returns the low 64 bits of its exact integer value, so the result is congruent to the true value modulo 2^64. Such a value raises integer overflow and inexact, never invalid. The range is asymmetric: -2^63 is representable, but +2^63 is an overflow. NaN and infinity give zero and raise invalid alone. Subnormal operands give zero with inexact. Deciding on traps and keeping a running status belong to the surrounding unit.

Top module: `f2i_convert`

## Requirements
- R1: After reset, out_valid, out_result and all three flags are zero. out_valid is high exactly in the cycle after a cycle with in_valid high. When in_valid is low, the result and flags keep their previous values.
- R2: A finite operand whose value is an integer in -2^63+1 .. 2^63-1 gives that integer in two's complement, with all flags clear.
- R3: An operand with a non-zero fractional part is rounded by in_mode and raises inexact alone. The encodings are 00 toward zero, 01 toward minus infinity, 10 to nearest with ties to even, and 11 toward plus infinity.
- R4: A negative operand gives the two's-complement negation of its rounded magnitude, taken modulo 2^64.
- R5: The operand +2^63 (0x43E0000000000000) gives 0x8000000000000000 with integer overflow and inexact. The operand -2^63 (0xC3E0000000000000) gives 0x8000000000000000 with no flags.
- R6: A finite operand whose magnitude is at least 2^63, other than -2^63, gives the low 64 bits of its exact signed value. It raises integer overflow and inexact, and invalid stays clear.
- R7: When the significand would need a left shift of 64 or more (biased exponent 1139 or above, not all ones), the result is 0 and integer overflow and inexact are raised.
- R8: An operand with the exponent field all ones (NaN or infinity, either sign) gives 0 and raises invalid only.
- R9: A subnormal operand gives 0 and raises inexact only, in every rounding mode. Either signed zero gives 0 with no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | binary64 operand: sign bit 63, exponent bits 62:52, fraction bits 51:0 |
| in_mode | input | 2 | Rounding mode (see R3) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 64 | Signed 64-bit integer result |
| out_inexact | output | 1 | Inexact flag |
| out_invalid | output | 1 | Invalid flag (NaN or infinity operand) |
| out_int_ovf | output | 1 | Integer overflow flag |

## Verification
The properties assume that in_valid, in_op and in_mode carry known values at every rising edge once reset has been released. They also assume that reset is held for at least one edge at the start. The bench drives every input only on the falling edge and holds it through the next rising edge, so each operand is captured once and cleanly. The bench keeps in_valid low between conversions, and it changes the operand while idle, so that the hold behaviour is actually exercised.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    parameter int EXP_W  = 11;
    parameter int FRAC_W = 52;
    parameter int INT_W  = 64;

    localparam int OP_W   = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int SH_W   = EXP_W + 2;
    localparam int OVF_SH = INT_W - 1 - FRAC_W;
    localparam int RS_CAP = SIG_W + 1;
    localparam int RS_W   = $clog2(RS_CAP + 1);
    localparam int EXT_W  = SIG_W + 1 + RS_CAP;
    localparam int LS_W   = $clog2(INT_W);

    typedef enum logic [1:0] {
        RM_ZERO = 2'b00,
        RM_NEG  = 2'b01,
        RM_EVEN = 2'b10,
        RM_POS  = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        CL_ZERO,
        CL_SUB,
        CL_NORM,
        CL_SPEC
    } opclass_e;

    typedef struct packed {
        logic                    sign;
        opclass_e                cls;
        logic [SIG_W-1:0]        sig;
        logic signed [SH_W-1:0]  shift;
    } fields_t;

    typedef struct packed {
        logic inexact;
        logic invalid;
        logic int_ovf;
    } flags_t;

    function automatic logic round_inc(rmode_e m, logic neg, logic lsb,
                                       logic g, logic s);
        logic up;
        case (m)
            RM_ZERO: up = 1'b0;
            RM_NEG:  up = neg & (g | s);
            RM_EVEN: up = g & (s | lsb);
            default: up = ~neg & (g | s);
        endcase
        return up;
    endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output fields_t         fld
);
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;

    always_comb begin
        ex = op[OP_W-2 -: EXP_W];
        fr = op[FRAC_W-1:0];
        fld.sign  = op[OP_W-1];
        fld.sig   = {1'b1, fr};
        fld.shift = $signed({2'b00, ex}) - $signed(SH_W'(BIAS + FRAC_W));
        if (&ex)
            fld.cls = CL_SPEC;
        else if (ex == '0)
            fld.cls = (fr == '0) ? CL_ZERO : CL_SUB;
        else
            fld.cls = CL_NORM;
    end
endmodule

// File: rtl/f2i_frac_round.sv
module f2i_frac_round
    import f2i_pkg::*;
(
    input  logic [SIG_W-1:0]       sig,
    input  logic signed [SH_W-1:0] shift,
    input  logic                   neg,
    input  rmode_e                 mode,
    output logic [SIG_W:0]         mag,
    output logic                   inexact
);
    logic [SH_W-1:0]  rs;
    logic [RS_W-1:0]  rsc;
    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] sh;
    logic [SIG_W-1:0] ipart;
    logic             g, s;

    always_comb begin
        rs  = -shift;
        rsc = (rs > SH_W'(RS_CAP)) ? RS_W'(RS_CAP) : rs[RS_W-1:0];
        ext = {sig, 1'b0, {RS_CAP{1'b0}}};
        sh  = ext >> rsc;
        ipart = sh[EXT_W-1 -: SIG_W];
        g   = sh[RS_CAP];
        s   = |sh[RS_CAP-1:0];
        inexact = g | s;
        mag = {1'b0, ipart} + (SIG_W+1)'(round_inc(mode, neg, ipart[0], g, s));
    end
endmodule

// File: rtl/f2i_int_wrap.sv
module f2i_int_wrap
    import f2i_pkg::*;
(
    input  logic [SIG_W-1:0]       sig,
    input  logic signed [SH_W-1:0] shift,
    input  logic                   neg,
    output logic [INT_W-1:0]       mag,
    output logic                   ovf
);
    logic far;
    logic at_min;

    always_comb begin
        far    = shift >= $signed(SH_W'(INT_W));
        at_min = neg && (sig[FRAC_W-1:0] == '0) && (shift == $signed(SH_W'(OVF_SH)));
        mag    = far ? '0 : (INT_W'(sig) << shift[LS_W-1:0]);
        ovf    = far || ((shift >= $signed(SH_W'(OVF_SH))) && !at_min);
    end
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_op,
    input  logic [1:0]       in_mode,
    output logic             out_valid,
    output logic [INT_W-1:0] out_result,
    output logic             out_inexact,
    output logic             out_invalid,
    output logic             out_int_ovf
);
    fields_t          fld;
    logic [SIG_W:0]   fr_mag;
    logic             fr_nx;
    logic [INT_W-1:0] wr_mag;
    logic             wr_ovf;
    logic [INT_W-1:0] mag;
    logic [INT_W-1:0] res_d;
    flags_t           flg_d;
    flags_t           flg_q;
    logic [INT_W-1:0] res_q;
    logic             vld_q;

    f2i_unpack u_unpack (.op(in_op), .fld(fld));

    f2i_frac_round u_frac (
        .sig(fld.sig), .shift(fld.shift), .neg(fld.sign),
        .mode(rmode_e'(in_mode)), .mag(fr_mag), .inexact(fr_nx)
    );

    f2i_int_wrap u_wrap (
        .sig(fld.sig), .shift(fld.shift), .neg(fld.sign),
        .mag(wr_mag), .ovf(wr_ovf)
    );

    always_comb begin
        mag   = '0;
        flg_d = '0;
        case (fld.cls)
            CL_SPEC: flg_d.invalid = 1'b1;
            CL_SUB:  flg_d.inexact = 1'b1;
            CL_NORM: begin
                if (fld.shift < 0) begin
                    mag = INT_W'(fr_mag);
                    flg_d.inexact = fr_nx;
                end else begin
                    mag = wr_mag;
                    flg_d.int_ovf = wr_ovf;
                    flg_d.inexact = wr_ovf;
                end
            end
            default: ;
        endcase
        res_d = fld.sign ? (~mag + INT_W'(1)) : mag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
            flg_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
                flg_q <= flg_d;
            end
        end
    end

    assign out_valid   = vld_q;
    assign out_result  = res_q;
    assign out_inexact = flg_q.inexact;
    assign out_invalid = flg_q.invalid;
    assign out_int_ovf = flg_q.int_ovf;
endmodule

// File: rtl/f2i_convert_chk.sv
module f2i_convert_chk
    import f2i_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OP_W-1:0]  in_op,
    input logic             out_valid,
    input logic [INT_W-1:0] out_result,
    input logic             out_inexact,
    input logic             out_invalid,
    input logic             out_int_ovf
);
    logic             exp_ones, exp_zero, frac_zero;
    assign exp_ones  = &in_op[OP_W-2 -: EXP_W];
    assign exp_zero  = in_op[OP_W-2 -: EXP_W] == '0;
    assign frac_zero = in_op[FRAC_W-1:0] == '0;

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_inexact)
                       && $stable(out_invalid) && $stable(out_int_ovf)));
    a_r8_special: assert property (@(posedge clk) disable iff (rst)
        (in_valid && exp_ones) |=> (out_invalid && !out_inexact
                                    && !out_int_ovf && out_result == '0));
    a_r9_subnormal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && exp_zero && !frac_zero) |=> (out_inexact && !out_invalid
                                    && !out_int_ovf && out_result == '0));
    a_r9_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && exp_zero && frac_zero) |=> (!out_inexact && !out_invalid
                                    && !out_int_ovf && out_result == '0));
    a_r6_ovf_implies_inexact: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_int_ovf) |-> (out_inexact && !out_invalid));
endmodule

bind f2i_convert f2i_convert_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .out_valid(out_valid), .out_result(out_result),
    .out_inexact(out_inexact), .out_invalid(out_invalid),
    .out_int_ovf(out_int_ovf)
);

// File: tb/f2i_convert_test.sv
`timescale 1ns/1ps
module f2i_convert_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] in_op;
    logic [1:0]  in_mode;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_inexact, out_invalid, out_int_ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    f2i_convert uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_mode(in_mode), .out_valid(out_valid), .out_result(out_result),
        .out_inexact(out_inexact), .out_invalid(out_invalid),
        .out_int_ovf(out_int_ovf)
    );

    task automatic check(string req, logic [63:0] er, logic ex, logic ev, logic eo);
        n_chk++;
        if (!out_valid || out_result !== er || out_inexact !== ex
            || out_invalid !== ev || out_int_ovf !== eo) begin
            n_bad++;
            $display("FAIL %s: got v=%0b r=%h nx=%0b nv=%0b iov=%0b, expected v=1 r=%h nx=%0b nv=%0b iov=%0b",
                     req, out_valid, out_result, out_inexact, out_invalid, out_int_ovf,
                     er, ex, ev, eo);
        end
    endtask

    task automatic conv(string req, logic [63:0] op, logic [1:0] m,
                        logic [63:0] er, logic ex, logic ev, logic eo);
        @(negedge clk);
        in_op = op; in_mode = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, er, ex, ev, eo);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_mode = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_chk++;
        if (out_valid !== 1'b0 || out_result !== '0 || out_inexact !== 1'b0
            || out_invalid !== 1'b0 || out_int_ovf !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got v=%0b r=%h flags=%0b%0b%0b, expected all zero",
                     out_valid, out_result, out_inexact, out_invalid, out_int_ovf);
        end
    endtask

    task automatic t_exact();
        conv("R2 one",      64'h3FF0000000000000, 2'b10, 64'd1, 0, 0, 0);
        conv("R2 2^62",     64'h43D0000000000000, 2'b00, 64'h4000000000000000, 0, 0, 0);
        conv("R2 top",      64'h43DFFFFFFFFFFFFF, 2'b11, 64'h7FFFFFFFFFFFFC00, 0, 0, 0);
        conv("R4 minus5",   64'hC014000000000000, 2'b01, 64'hFFFFFFFFFFFFFFFB, 0, 0, 0);
    endtask

    task automatic t_round();
        conv("R3 2.5 chop", 64'h4004000000000000, 2'b00, 64'd2, 1, 0, 0);
        conv("R3 2.5 down", 64'h4004000000000000, 2'b01, 64'd2, 1, 0, 0);
        conv("R3 2.5 even", 64'h4004000000000000, 2'b10, 64'd2, 1, 0, 0);
        conv("R3 2.5 up",   64'h4004000000000000, 2'b11, 64'd3, 1, 0, 0);
        conv("R3 3.5 even", 64'h400C000000000000, 2'b10, 64'd4, 1, 0, 0);
        conv("R3 0.5 even", 64'h3FE0000000000000, 2'b10, 64'd0, 1, 0, 0);
        conv("R3 0.5 up",   64'h3FE0000000000000, 2'b11, 64'd1, 1, 0, 0);
        conv("R3 tiny up",  64'h0010000000000000, 2'b11, 64'd1, 1, 0, 0);
        conv("R4 -2.5 chop",64'hC004000000000000, 2'b00, 64'hFFFFFFFFFFFFFFFE, 1, 0, 0);
        conv("R4 -2.5 down",64'hC004000000000000, 2'b01, 64'hFFFFFFFFFFFFFFFD, 1, 0, 0);
        conv("R4 -2.5 even",64'hC004000000000000, 2'b10, 64'hFFFFFFFFFFFFFFFE, 1, 0, 0);
        conv("R4 -2.5 up",  64'hC004000000000000, 2'b11, 64'hFFFFFFFFFFFFFFFE, 1, 0, 0);
        conv("R4 -0.5 down",64'hBFE0000000000000, 2'b01, 64'hFFFFFFFFFFFFFFFF, 1, 0, 0);
        conv("R4 -tiny dn", 64'h8010000000000000, 2'b01, 64'hFFFFFFFFFFFFFFFF, 1, 0, 0);
    endtask

    task automatic t_edge63();
        conv("R5 +2^63",    64'h43E0000000000000, 2'b10, 64'h8000000000000000, 1, 0, 1);
        conv("R5 -2^63",    64'hC3E0000000000000, 2'b10, 64'h8000000000000000, 0, 0, 0);
    endtask

    task automatic t_wrap();
        conv("R6 2^63+2^11",  64'h43E0000000000001, 2'b00, 64'h8000000000000800, 1, 0, 1);
        conv("R6 neg wrap",   64'hC3E0000000000001, 2'b00, 64'h7FFFFFFFFFFFF800, 1, 0, 1);
        conv("R6 1.5*2^64",   64'h43F8000000000000, 2'b11, 64'h8000000000000000, 1, 0, 1);
        conv("R6 2^64",       64'h43F0000000000000, 2'b01, 64'h0, 1, 0, 1);
        conv("R7 huge",       64'h7FE0000000000000, 2'b10, 64'h0, 1, 0, 1);
        conv("R7 shift64",    64'hC730000000000000, 2'b10, 64'h0, 1, 0, 1);
    endtask

    task automatic t_special();
        conv("R8 nan",  64'h7FF8000000000000, 2'b10, 64'h0, 0, 1, 0);
        conv("R8 +inf", 64'h7FF0000000000000, 2'b11, 64'h0, 0, 1, 0);
        conv("R8 -inf", 64'hFFF0000000000000, 2'b01, 64'h0, 0, 1, 0);
        conv("R9 sub up",   64'h0000000000000001, 2'b11, 64'h0, 1, 0, 0);
        conv("R9 -sub down",64'h800FFFFFFFFFFFFF, 2'b01, 64'h0, 1, 0, 0);
        conv("R9 +zero",    64'h0000000000000000, 2'b11, 64'h0, 0, 0, 0);
        conv("R9 -zero",    64'h8000000000000000, 2'b01, 64'h0, 0, 0, 0);
    endtask

    task automatic t_hold();
        conv("R1 load", 64'h4014000000000000, 2'b00, 64'd5, 0, 0, 0);
        @(negedge clk);
        in_op = 64'h7FF0000000000000; in_mode = 2'b11;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_result !== 64'd5 || out_inexact !== 1'b0
            || out_invalid !== 1'b0 || out_int_ovf !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 hold: got v=%0b r=%h flags=%0b%0b%0b, expected v=0 r=%h flags=000",
                     out_valid, out_result, out_inexact, out_invalid, out_int_ovf, 64'd5);
        end
    endtask

    initial begin
        t_reset();
        t_exact();
        t_round();
        t_edge63();
        t_wrap();
        t_special();
        t_hold();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule